// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, from the six destination-address bytes at the head of each incoming frame, whether the frame should be kept. Bytes arrive one per cycle on a byte stream qualified by a valid strobe, with a start-of-frame flag on the first byte. While the bytes stream past, the filter compares them against a programmed station address, tracks whether all of them are 0xFF, remembers the group bit of the first byte and folds each byte into a running CRC-32.

One cycle after the sixth byte the block pulses a done strobe together with its verdict. A frame is kept when the promiscuous override is on, when it carries the station's own address, when it is the all-ones broadcast address and broadcast rejection is off, or when it is any other group address whose bit in a 64-entry hash table is set. Frame storage and frame check sequence checking belong to other blocks.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `done_o` and `accept_o` are 0.
- R2: The station address is read with wire byte 0 in `sta_hi_i[15:8]`, byte 1 in `sta_hi_i[7:0]`, and bytes 2 to 5 in `sta_lo_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. A frame whose six bytes all equal the corresponding station bytes is accepted, whatever the other mode inputs are.
- R3: The destination FF:FF:FF:FF:FF:FF is accepted when `bcast_rej_i` is 0.
- R4: When `bcast_rej_i` is 1 and `promisc_i` is 0, FF:FF:FF:FF:FF:FF is rejected; the hash table is never consulted for that address.
- R5: For a group address (bit 0 of byte 0 set) other than broadcast, the hash index is bits 31:26 of a CRC-32 register that starts at all ones and absorbs the six bytes LSB first with the reflected polynomial 0xEDB88320 and no final inversion. Index bit 5 picks `hash_hi_i` (1) or `hash_lo_i` (0) and bits 4:0 pick the bit; the frame is accepted when that bit is 1, so an all-ones table accepts every group address.
- R6: A group address whose hash bit is 0, and an individual address (bit 0 of byte 0 clear) that differs from the station address in any byte, are rejected.
- R7: When `promisc_i` is 1 every frame is accepted, including a broadcast with `bcast_rej_i` set.
- R8: `done_o` is high for exactly one cycle, the cycle after the sixth valid byte is taken; `accept_o` is 0 whenever `done_o` is 0. The mode and hash inputs are used as they stand when the sixth byte is taken.
- R9: A byte with `sof_i` and `byte_vld_i` both high starts a new address, discarding any partial one; a frame cut short this way produces no decision.
- R10: Cycles with `byte_vld_i` low pause collection without effect, and valid bytes after the sixth without `sof_i` are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | First byte of a frame, qualified by `byte_vld_i` |
| byte_vld_i | input | 1 | `byte_i` carries a frame byte this cycle |
| byte_i | input | 8 | Frame byte, wire order |
| sta_lo_i | input | 32 | Station address bytes 2 to 5 |
| sta_hi_i | input | 16 | Station address bytes 0 and 1 |
| hash_lo_i | input | 32 | Group hash bits for indices 0 to 31 |
| hash_hi_i | input | 32 | Group hash bits for indices 32 to 63 |
| bcast_rej_i | input | 1 | Reject the all-ones broadcast address |
| promisc_i | input | 1 | Accept every frame |
| done_o | output | 1 | One-cycle strobe: verdict valid |
| accept_o | output | 1 | Verdict, 1 = keep the frame |

## Verification
The bound checker watches, on every cycle, that a verdict never appears without its strobe, that the strobe only follows a cycle with a valid byte and never lasts two cycles, and that the promiscuous override always yields acceptance. Which address classes pass or fail, the station byte mapping, the exact CRC-derived hash bit and the half of the table it lands in, and the restart and ignore behaviour around start-of-frame can only be shown by the bench's frames, which compute the expected verdict and hash index on their own.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
    localparam int POS_W      = $clog2(ADDR_BYTES + 1);
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_BITS  = 2 ** HASH_IDX_W;
    localparam int HASH_HALF  = HASH_BITS / 2;
    localparam int STA_LO_W   = 32;
    localparam int STA_HI_W   = ADDR_BYTES * BYTE_W - STA_LO_W;

    typedef struct packed {
        logic [POS_W-1:0] cnt;     // bytes taken so far, 0 = idle
        logic [CRC_W-1:0] crc;     // running CRC register
        logic             uc_hit;  // all bytes so far equal the station bytes
        logic             bc_hit;  // all bytes so far are 0xFF
        logic             mc;      // group bit of byte 0
        logic             done;
        logic             accept;
    } daf_state_t;
endpackage

// File: rtl/daf_crc_step.sv
module daf_crc_step #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] acc;

    // Reflected serial CRC, data LSB first, unrolled over one byte.
    always_comb begin
        acc = crc_i;
        for (int i = 0; i < DATA_W; i++) begin
            acc = (acc >> 1) ^ ((acc[0] ^ data_i[i]) ? POLY : '0);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/daf_hash_lookup.sv
module daf_hash_lookup #(
    parameter int IDX_W = 6,
    localparam int HALF = (2 ** IDX_W) / 2
) (
    input  logic [HALF-1:0]  lo_i,
    input  logic [HALF-1:0]  hi_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             hit_o
);
    // Top index bit picks the half, the rest picks the bit.
    assign hit_o = idx_i[IDX_W-1] ? hi_i[idx_i[IDX_W-2:0]] : lo_i[idx_i[IDX_W-2:0]];
endmodule

// File: rtl/daf_station_byte.sv
module daf_station_byte #(
    parameter int N_BYTES = 6,
    parameter int BYTE_W  = 8,
    parameter int LO_W    = 32,
    parameter int POS_W   = 3,
    localparam int HI_W   = N_BYTES * BYTE_W - LO_W
) (
    input  logic [LO_W-1:0]   sta_lo_i,
    input  logic [HI_W-1:0]   sta_hi_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [BYTE_W-1:0] exp_o
);
    logic [N_BYTES*BYTE_W-1:0] flat;
    logic [BYTE_W-1:0]         sta_bytes [N_BYTES];

    // Wire byte 0 sits in the most significant byte of {hi, lo}.
    assign flat = {sta_hi_i, sta_lo_i};

    for (genvar k = 0; k < N_BYTES; k++) begin : g_split
        assign sta_bytes[k] = flat[(N_BYTES-k)*BYTE_W-1 -: BYTE_W];
    end

    always_comb begin
        exp_o = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (pos_i == POS_W'(k)) exp_o = sta_bytes[k];
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                byte_vld_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic [STA_LO_W-1:0] sta_lo_i,
    input  logic [STA_HI_W-1:0] sta_hi_i,
    input  logic [HASH_HALF-1:0] hash_lo_i,
    input  logic [HASH_HALF-1:0] hash_hi_i,
    input  logic                bcast_rej_i,
    input  logic                promisc_i,
    output logic                done_o,
    output logic                accept_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

    daf_state_t s_d, s_q;

    logic             start, cont;
    logic [POS_W-1:0] pos;
    logic [CRC_W-1:0] crc_seed, crc_next;
    logic [BYTE_W-1:0] exp_byte;
    logic             hash_hit;
    logic             uc_n, bc_n, mc_n;

    assign start    = byte_vld_i & sof_i;
    assign cont     = byte_vld_i & ~sof_i & (s_q.cnt != '0);
    assign pos      = start ? '0 : s_q.cnt;
    assign crc_seed = start ? '1 : s_q.crc;

    daf_crc_step #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (crc_seed),
        .data_i (byte_i),
        .crc_o  (crc_next)
    );

    daf_station_byte #(.N_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .LO_W(STA_LO_W), .POS_W(POS_W)) u_sta (
        .sta_lo_i (sta_lo_i),
        .sta_hi_i (sta_hi_i),
        .pos_i    (pos),
        .exp_o    (exp_byte)
    );

    daf_hash_lookup #(.IDX_W(HASH_IDX_W)) u_hash (
        .lo_i  (hash_lo_i),
        .hi_i  (hash_hi_i),
        .idx_i (crc_next[CRC_W-1 -: HASH_IDX_W]),
        .hit_o (hash_hit)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.accept = 1'b0;
        uc_n = (start | s_q.uc_hit) & (byte_i == exp_byte);
        bc_n = (start | s_q.bc_hit) & (byte_i == '1);
        mc_n = start ? byte_i[0] : s_q.mc;
        if (start || cont) begin
            s_d.crc    = crc_next;
            s_d.uc_hit = uc_n;
            s_d.bc_hit = bc_n;
            s_d.mc     = mc_n;
            if (pos == LAST_POS) begin
                s_d.cnt    = '0;
                s_d.done   = 1'b1;
                s_d.accept = promisc_i
                           | uc_n
                           | (bc_n & ~bcast_rej_i)
                           | (mc_n & ~bc_n & hash_hit);
            end else begin
                s_d.cnt = pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, crc: '1, uc_hit: 1'b0, bc_hit: 1'b0,
                     mc: 1'b0, done: 1'b0, accept: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o   = s_q.done;
    assign accept_o = s_q.accept;
endmodule

// File: rtl/daf_checks.sv
module daf_checks (
    input logic clk,
    input logic rst_n,
    input logic byte_vld_i,
    input logic promisc_i,
    input logic done_o,
    input logic accept_o
);
    assert_verdict_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> done_o);

    assert_strobe_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(byte_vld_i));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(promisc_i)) |-> accept_o);
endmodule

bind dest_addr_filter daf_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld_i),
    .promisc_i  (promisc_i),
    .done_o     (done_o),
    .accept_o   (accept_o)
);

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [31:0] sta_lo_i = 32'h22334455;
    logic [15:0] sta_hi_i = 16'h0211;
    logic [31:0] hash_lo_i = '0, hash_hi_i = '0;
    logic        bcast_rej_i = 1'b0, promisc_i = 1'b0;
    logic        done_o, accept_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    dest_addr_filter u0 (.*);

    localparam logic [47:0] STA = 48'h021122334455;
    localparam int NV = 12;
    // {addr[47:0], bcast_rej, promisc, hash_all_ones, expected_accept}
    localparam logic [51:0] VEC [NV] = '{
        {STA,             4'b0001},  // R2 exact match
        {48'h021122334454, 4'b0000}, // R6 last byte differs
        {48'h001122334455, 4'b0000}, // R6 first byte differs
        {48'hFFFFFFFFFFFF, 4'b0001}, // R3 broadcast allowed
        {48'hFFFFFFFFFFFF, 4'b1000}, // R4 broadcast rejected
        {48'hFFFFFFFFFFFF, 4'b1010}, // R4 full hash table does not rescue
        {48'hFFFFFFFFFFFF, 4'b1101}, // R7 promisc beats reject
        {48'h0A0000000001, 4'b0101}, // R7 stranger accepted
        {48'h01005E000001, 4'b0011}, // R5 all-ones table
        {48'h01005E000001, 4'b0000}, // R6 empty table
        {STA,             4'b1001},  // R2 reject bit irrelevant to own address
        {48'h110222334455, 4'b0000}  // R2 byte 0/1 order matters
    };
    localparam string VTAG [NV] = '{"R2","R6","R6","R3","R4","R4","R7","R7","R5","R6","R2","R2"};

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb = c[0] ^ b[j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    // Drives six bytes (gap idle cycles between them), returns the verdict.
    task automatic send_addr(input logic [47:0] a, input int gap, input string req,
                             output logic acc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(req, done_o, 1'b0);   // no early decision
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = a[47-8*i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk("R10", done_o, 1'b0);
                    sof_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'hA5;
                end
            end
        end
        @(negedge clk);
        sof_i = 1'b0; byte_vld_i = 1'b0;
        chk("R8", done_o, 1'b1);
        acc = accept_o;
        @(negedge clk);
        chk("R8", done_o, 1'b0);
        chk("R8", accept_o, 1'b0);
    endtask

    task automatic set_hash_bit(input logic [5:0] idx, input logic invert);
        hash_lo_i = '0; hash_hi_i = '0;
        if (idx[5]) hash_hi_i[idx[4:0]] = 1'b1;
        else        hash_lo_i[idx[4:0]] = 1'b1;
        if (invert) begin hash_lo_i = ~hash_lo_i; hash_hi_i = ~hash_hi_i; end
    endtask

    initial begin
        logic acc;
        logic [47:0] mcs [4] = '{48'h01005E0000FB, 48'h333300000001,
                                 48'h0180C200000E, 48'h01005E7F1234};
        repeat (3) @(negedge clk);
        chk("R1", done_o, 1'b0);
        chk("R1", accept_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", done_o, 1'b0);
        chk("R1", accept_o, 1'b0);

        for (int v = 0; v < NV; v++) begin
            bcast_rej_i = VEC[v][3];
            promisc_i   = VEC[v][2];
            hash_lo_i   = {32{VEC[v][1]}};
            hash_hi_i   = {32{VEC[v][1]}};
            send_addr(VEC[v][51:4], 0, VTAG[v], acc);
            chk(VTAG[v], acc, VEC[v][0]);
        end
        bcast_rej_i = 1'b0; promisc_i = 1'b0;

        // R5: exactly the computed hash bit accepts; every other bit does not.
        foreach (mcs[m]) begin
            set_hash_bit(hash_idx(mcs[m]), 1'b0);
            send_addr(mcs[m], 0, "R5", acc);
            chk("R5", acc, 1'b1);
            set_hash_bit(hash_idx(mcs[m]), 1'b1);
            send_addr(mcs[m], 0, "R6", acc);
            chk("R6", acc, 1'b0);
        end
        hash_lo_i = '0; hash_hi_i = '0;

        // R9: partial station address cut by a new start of frame.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = STA[47-8*i -: 8];
        end
        send_addr(48'h021100000000, 0, "R9", acc);
        chk("R9", acc, 1'b0);
        // R9: partial foreign address then a full station address.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = 8'h77;
        end
        send_addr(STA, 0, "R9", acc);
        chk("R9", acc, 1'b1);

        // R10: idle gaps between bytes.
        send_addr(STA, 2, "R10", acc);
        chk("R10", acc, 1'b1);
        // R10: trailing bytes without start of frame give no decision.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R10", done_o, 1'b0);
            sof_i = 1'b0; byte_vld_i = 1'b1; byte_i = STA[47-8*(i%6) -: 8];
        end
        @(negedge clk); byte_vld_i = 1'b0;
        chk("R10", done_o, 1'b0);
        @(negedge clk);
        chk("R10", done_o, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule